// File: doc/BRIEF.md
# Misaligned Access Bus-Cycle Splitter

This block sits between a processor's load/store path and a 32-bit external bus. It takes one data access at a time: a byte address, a size of 1, 2 or 4 bytes, a memory or I/O select, a read or write select, write data and a lock flag. It runs that access as bus cycles with an address strobe and a ready handshake. An access that stays inside one aligned doubleword needs one bus cycle. An access that crosses a doubleword boundary needs two bus cycles. Each of those cycles has its own strobe and its own ready.

The block steers write bytes onto the byte lanes selected by their addresses. It collects read bytes from the lanes into a holding register. It returns the assembled result with a single completion pulse. The order of the two cycles depends on the access type. I/O writes put the upper doubleword first. Every other type puts the lower doubleword first. While a locked access is in progress, the lock output stays asserted. For a locked access that takes two cycles, a split indicator is also raised.

Top module: `misalign_splitter`

## Requirements
- R1: An access whose bytes all lie in one aligned doubleword runs as exactly one bus cycle. Request byte i occupies byte address addr+i. `bus_be_o` bit k is set exactly when lane k = (addr+i) mod 4 for some i below the size. The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R2: An access that crosses a doubleword boundary runs as two bus cycles. Each cycle has a one-clock `bus_ads_o` pulse. The second pulse comes only after the first cycle's ready has been accepted.
- R3: `bus_addr_o` carries address bits [31:2] of the doubleword that the cycle serves. For memory reads, memory writes and I/O reads, the lower doubleword goes first. For I/O writes (`req_io_i`=1, `req_write_i`=1) the higher doubleword goes first. `bus_mio_o` is 1 for memory. `bus_wr_o` is 1 for writes.
- R4: On a write, request data byte i (bits 8i+7..8i) appears on lane (addr+i) mod 4, in the cycle for that byte's doubleword.
- R5: On a read, byte i of `rdata_o` is lane (addr+i) mod 4 of the data returned in the cycle for that byte's doubleword. Bytes beyond the size read as zero. `done_o` pulses for one clock, in the clock after the last ready is accepted.
- R6: For a locked access, `bus_lock_o` stays high from the first strobe through the last ready. `bus_split_o` is high over the same span only when the access is both locked and two-cycle. Otherwise both stay low.
- R7: `req_ready_o` is high only when the block is idle. A `req_valid_i` asserted while an access is in progress is ignored.
- R8: `bus_rdy_i` is sampled only after the strobe clock of a cycle. A ready seen during the strobe clock neither ends the cycle nor produces a completion.
- R9: After reset, `req_ready_o` is high. `bus_ads_o`, `bus_lock_o`, `bus_split_o` and `done_o` are low, and `bus_be_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Block idle, request taken this clock |
| req_addr_i | input | 32 | Byte address |
| req_size_i | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| req_io_i | input | 1 | 1: I/O space, 0: memory |
| req_write_i | input | 1 | 1: write, 0: read |
| req_lock_i | input | 1 | Locked access |
| req_wdata_i | input | 32 | Write data, byte 0 at the address |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read result, valid with done_o |
| bus_ads_o | output | 1 | Address strobe |
| bus_addr_o | output | 30 | Doubleword address |
| bus_be_o | output | 4 | Byte enables |
| bus_mio_o | output | 1 | 1: memory cycle |
| bus_wr_o | output | 1 | 1: write cycle |
| bus_wdata_o | output | 32 | Lane-steered write data |
| bus_rdata_i | input | 32 | Read data from bus |
| bus_rdy_i | input | 1 | Cycle ready |
| bus_lock_o | output | 1 | Bus lock |
| bus_split_o | output | 1 | Locked two-cycle transfer |

## Verification
A request is accepted on a clock edge. The strobe for the first cycle is high in the clock that follows that edge. The wait phase starts one clock later, and each ready is taken on the first edge that falls within the wait phase. The second strobe is then due one clock after the first ready. `done_o` and the merged `rdata_o` are due one clock after the last ready, and the block is idle one clock after that. The bench drives inputs and samples outputs on falling edges. It follows each access clock by clock to those exact points, with varied wait lengths and early readies.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_C1_ADDR, ST_C1_WAIT, ST_C2_ADDR, ST_C2_WAIT, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES,
  localparam int OW = $clog2(LANES)
) (
  input  logic [OW-1:0]    off_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [LANES-1:0] lo_be_o,
  output logic [LANES-1:0] hi_be_o,
  output logic [DW-1:0]    lo_data_o,
  output logic [DW-1:0]    hi_data_o,
  output logic             split_o
);
  logic [2*LANES-1:0] len_mask, span;
  logic [2*DW-1:0]    wide;

  always_comb begin
    len_mask = '0;
    for (int i = 0; i < LANES; i++)
      if (i < (32'sd1 <<< size_i)) len_mask[i] = 1'b1;
    span = len_mask << off_i;
    wide = {{DW{1'b0}}, wdata_i} << {off_i, 3'b000};
  end

  assign lo_be_o   = span[LANES-1:0];
  assign hi_be_o   = span[2*LANES-1:LANES];
  assign lo_data_o = wide[DW-1:0];
  assign hi_data_o = wide[2*DW-1:DW];
  assign split_o   = |hi_be_o;
endmodule

// File: rtl/read_merge.sv
module read_merge #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES,
  localparam int OW = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_lo_i,
  input  logic          cap_hi_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic [OW-1:0] off_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0]   hold_lo, hold_hi;
  logic [2*DW-1:0] shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_lo <= '0;
      hold_hi <= '0;
    end else begin
      if (cap_lo_i) hold_lo <= bus_rdata_i;
      if (cap_hi_i) hold_hi <= bus_rdata_i;
    end
  end

  always_comb begin
    shifted = {hold_hi, hold_lo} >> {off_i, 3'b000};
    rdata_o = '0;
    for (int i = 0; i < LANES; i++)
      if (i < (32'sd1 <<< size_i)) rdata_o[8*i +: 8] = shifted[8*i +: 8];
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import misalign_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       split_i,
  input  logic       hi_first_i,
  input  logic       rdy_i,
  output seq_state_e state_o,
  output logic       ads_o,
  output logic       active_o,
  output logic       use_hi_o,
  output logic       cap_lo_o,
  output logic       cap_hi_o,
  output logic       done_o,
  output logic       idle_o
);
  seq_state_e state_q, state_d;
  logic waiting, second;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_C1_ADDR;
      ST_C1_ADDR: state_d = ST_C1_WAIT;
      ST_C1_WAIT: if (rdy_i) state_d = split_i ? ST_C2_ADDR : ST_DONE;
      ST_C2_ADDR: state_d = ST_C2_WAIT;
      ST_C2_WAIT: if (rdy_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign second   = (state_q == ST_C2_ADDR) || (state_q == ST_C2_WAIT);
  assign waiting  = (state_q == ST_C1_WAIT) || (state_q == ST_C2_WAIT);
  assign ads_o    = (state_q == ST_C1_ADDR) || (state_q == ST_C2_ADDR);
  assign active_o = ads_o || waiting;
  // upper doubleword served in phase 2 normally, phase 1 when reversed
  assign use_hi_o = second ^ hi_first_i;
  assign cap_lo_o = waiting && rdy_i && !use_hi_o;
  assign cap_hi_o = waiting && rdy_i && use_hi_o;
  assign done_o   = (state_q == ST_DONE);
  assign idle_o   = (state_q == ST_IDLE);
  assign state_o  = state_q;

  assert_ads_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |=> !ads_o);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && idle_o));
  assert_early_rdy_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |=> (!done_o && !ads_o && active_o));
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import misalign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int DW    = 8 * LANES,
  localparam int OW    = $clog2(LANES),
  localparam int DWA_W = ADDR_W - OW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_io_i,
  input  logic              req_write_i,
  input  logic              req_lock_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              bus_ads_o,
  output logic [DWA_W-1:0]  bus_addr_o,
  output logic [LANES-1:0]  bus_be_o,
  output logic              bus_mio_o,
  output logic              bus_wr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic [DW-1:0]     bus_rdata_i,
  input  logic              bus_rdy_i,
  output logic              bus_lock_o,
  output logic              bus_split_o
);
  logic [DWA_W-1:0] dwa_q;
  logic [OW-1:0]    off_q;
  logic [1:0]       size_q;
  logic             io_q, wr_q, lock_q;
  logic [DW-1:0]    wdata_q;

  logic             start, idle, active, use_hi, cap_lo, cap_hi, split, hi_first;
  logic [LANES-1:0] lo_be, hi_be;
  logic [DW-1:0]    lo_data, hi_data;
  seq_state_e       state;

  assign start = req_valid_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dwa_q   <= '0;
      off_q   <= '0;
      size_q  <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      lock_q  <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      dwa_q   <= req_addr_i[ADDR_W-1:OW];
      off_q   <= req_addr_i[OW-1:0];
      size_q  <= req_size_i;
      io_q    <= req_io_i;
      wr_q    <= req_write_i;
      lock_q  <= req_lock_i;
      wdata_q <= req_wdata_i;
    end
  end

  lane_steer #(.LANES(LANES)) u_steer (
    .off_i(off_q), .size_i(size_q), .wdata_i(wdata_q),
    .lo_be_o(lo_be), .hi_be_o(hi_be), .lo_data_o(lo_data), .hi_data_o(hi_data),
    .split_o(split)
  );

  assign hi_first = split && io_q && wr_q;

  seq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .split_i(split),
    .hi_first_i(hi_first), .rdy_i(bus_rdy_i), .state_o(state), .ads_o(bus_ads_o),
    .active_o(active), .use_hi_o(use_hi), .cap_lo_o(cap_lo), .cap_hi_o(cap_hi),
    .done_o(done_o), .idle_o(idle)
  );

  read_merge #(.LANES(LANES)) u_merge (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
    .bus_rdata_i(bus_rdata_i), .off_i(off_q), .size_i(size_q), .rdata_o(rdata_o)
  );

  assign req_ready_o = idle;
  assign bus_addr_o  = dwa_q + DWA_W'(use_hi);
  assign bus_be_o    = active ? (use_hi ? hi_be : lo_be) : '0;
  assign bus_wdata_o = (active && wr_q) ? (use_hi ? hi_data : lo_data) : '0;
  assign bus_mio_o   = active && !io_q;
  assign bus_wr_o    = active && wr_q;
  assign bus_lock_o  = active && lock_q;
  assign bus_split_o = active && lock_q && split;

  assert_split_needs_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_split_o |-> bus_lock_o);
  assert_lock_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && !(state == ST_C2_WAIT && bus_rdy_i)
     && !(state == ST_C1_WAIT && bus_rdy_i && !split)) |=> bus_lock_o);
  assert_busy_not_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ads_o |-> !req_ready_o);
  assert_be_present_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ads_o |-> (bus_be_o != '0));
  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_be_o != '0 && !bus_ads_o && !bus_rdy_i) |=> $stable(bus_addr_o));
endmodule

// File: tb/tb_misalign_splitter.sv
module tb_misalign_splitter;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_io_i = 1'b0, req_write_i = 1'b0, req_lock_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        done_o;
  logic [31:0] rdata_o;
  logic        bus_ads_o;
  logic [29:0] bus_addr_o;
  logic [3:0]  bus_be_o;
  logic        bus_mio_o, bus_wr_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_rdy_i = 1'b0;
  logic        bus_lock_o, bus_split_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  misalign_splitter dut (.*);

  function automatic logic [31:0] mem_word(logic [29:0] a);
    return ({2'b00, a} * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] addr, input logic [1:0] sz, input bit io, input bit wr,
                         input bit lk, input logic [31:0] wd, input int wt, input bit poke);
    int n = 1 << sz;
    int off = int'(addr[1:0]);
    bit sp = (off + n) > 4;
    bit hf = sp && io && wr;
    logic [3:0] be_lo = '0, be_hi = '0;
    logic [29:0] c_addr [2];
    logic [3:0]  c_be [2];
    logic [31:0] c_wd [2];
    logic [31:0] exp_rd = '0;
    int ncyc = sp ? 2 : 1;
    for (int i = 0; i < n; i++) begin
      if (off + i < 4) be_lo[off+i] = 1'b1; else be_hi[off+i-4] = 1'b1;
    end
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = addr; req_size_i = sz; req_io_i = io;
    req_write_i = wr; req_lock_i = lk; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      bit is_hi = (c == 1) ^ hf;
      chk(bus_ads_o == 1'b1, "R2 strobe", {31'b0, bus_ads_o}, 1);
      chk(req_ready_o == 1'b0, "R7 busy", {31'b0, req_ready_o}, 0);
      c_addr[c] = bus_addr_o; c_be[c] = bus_be_o; c_wd[c] = bus_wdata_o;
      chk(bus_addr_o == addr[31:2] + 30'(is_hi), "R3 order/addr", {2'b0, bus_addr_o},
          {2'b0, addr[31:2] + 30'(is_hi)});
      chk(bus_be_o == (is_hi ? be_hi : be_lo), "R1 be", {28'b0, bus_be_o},
          {28'b0, is_hi ? be_hi : be_lo});
      chk(bus_mio_o == !io && bus_wr_o == wr, "R3 type", {30'b0, bus_mio_o, bus_wr_o}, {30'b0, !io, wr});
      chk(bus_lock_o == lk && bus_split_o == (lk && sp), "R6 lock/split",
          {30'b0, bus_lock_o, bus_split_o}, {30'b0, lk, lk && sp});
      if (poke) begin
        bus_rdy_i = 1'b1; bus_rdata_i = 32'hDEAD_BEEF;
        @(negedge clk_i);
        bus_rdy_i = 1'b0;
        chk(!bus_ads_o && !done_o && bus_be_o == c_be[c], "R8 early ready", {31'b0, done_o}, 0);
      end else @(negedge clk_i);
      for (int w = 0; w < wt; w++) begin
        if (w == 0) begin req_valid_i = 1'b1; req_addr_i = addr + 32'h40; end
        chk(!bus_ads_o && bus_lock_o == lk && !done_o, "R6 wait hold", {31'b0, bus_lock_o}, {31'b0, lk});
        @(negedge clk_i);
        req_valid_i = 1'b0;
      end
      bus_rdy_i = 1'b1; bus_rdata_i = mem_word(c_addr[c]);
      @(negedge clk_i);
      bus_rdy_i = 1'b0; bus_rdata_i = '0;
    end
    chk(done_o == 1'b1 && !bus_ads_o, "R5 done", {31'b0, done_o}, 1);
    if (wr) begin
      for (int i = 0; i < n; i++) begin
        int ln = (off + i) % 4;
        bit hi = (off + i) >= 4;
        int c = (hi ^ hf) ? 1 : 0;
        chk(c_wd[c][8*ln +: 8] == wd[8*i +: 8], "R4 lane", {24'b0, c_wd[c][8*ln +: 8]}, {24'b0, wd[8*i +: 8]});
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        int ln = (off + i) % 4;
        logic [31:0] w32 = mem_word(addr[31:2] + 30'((off + i) >= 4));
        exp_rd[8*i +: 8] = w32[8*ln +: 8];
      end
      chk(rdata_o == exp_rd, "R5 merge", rdata_o, exp_rd);
    end
    @(negedge clk_i);
    chk(!done_o && req_ready_o && !bus_ads_o && !bus_lock_o, "R7 idle after", {31'b0, req_ready_o}, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !bus_ads_o && !bus_lock_o && !bus_split_o && !done_o && bus_be_o == 0,
        "R9 reset", {27'b0, req_ready_o, bus_be_o}, 32'h10);
    run_one(32'h0000_800E, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 1, 1'b0);
    run_one(32'h0000_008E, 2'd2, 1'b1, 1'b1, 1'b0, 32'h1122_3344, 0, 1'b0);
    begin
      int t = 0;
      for (int lk = 0; lk < 2; lk++)
        for (int io = 0; io < 2; io++)
          for (int wr = 0; wr < 2; wr++)
            for (int sz = 0; sz < 3; sz++)
              for (int off = 0; off < 4; off++) begin
                run_one(32'h0000_7F00 + 32'(t * 4 + off), 2'(sz), io[0], wr[0], lk[0],
                        32'(t) * 32'h0123_4567 ^ 32'h89AB_CDEF, t % 3, (t % 5) == 1);
                t++;
              end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule